// File: doc/BRIEF.md
# Iterative Multi-Mode Integer Divider

This block is the divide unit of a processor execution pipeline. A request carries two 64-bit operands, a 5-bit destination register number and five mode flags: signed, word (32-bit), extended, modulus and record. The unit works out the quotient or remainder one bit per clock with a restoring shift-and-subtract loop on operand magnitudes. At the end it corrects the sign, checks for overflow and presents a write-back value for one cycle.

Extended mode divides the dividend operand shifted left by the operand width. That is a 128-bit numerator in 64-bit mode, or the low word placed in the upper half in word mode. Any quotient that does not fit the destination width, and any division by zero, yields zero. With the record flag the unit also writes a 4-bit condition field. The field comes from a signed compare of the 64-bit result against zero.

A request is taken only while the unit is idle. A request seen while it is busy is dropped.

Top module: `int_divider`

## Requirements
- R1: For non-extended 64-bit division the result is the truncating quotient. With the signed flag the operands are two's complement, otherwise unsigned. Example: 0x10001000 / 0x1111 = 0xF001.
- R2: `res_valid` is high for exactly one cycle per accepted request. It rises on the 65th rising edge after the edge that accepts the request, which is within 67 cycles, and is low at all other times.
- R3: With the result, `res_dest` equals the `dest_reg` given with that request and `res_wen` is high.
- R4: A zero effective divisor gives an all-zero result in every mode, including modulus. The effective divisor is the low word in word mode.
- R5: Signed 64-bit 0x8000000000000000 / -1 gives zero. Signed word-mode division whose low words are 0x80000000 / -1 also gives zero.
- R6: Extended 64-bit mode divides {dividend, 64 zero bits}. Unsigned, the result is nonzero only when divisor > dividend. Signed, a quotient outside the signed 64-bit range gives zero.
- R7: Word mode uses only the low 32 bits of both operands. A quotient is returned with bits 63:32 cleared. Extended word mode divides {low word, 32 zero bits}. It gives zero when the quotient does not fit 32 bits: the signed range when signed, unsigned 32 bits otherwise.
- R8: Modulus mode returns the truncating remainder, whose sign follows the dividend, and ignores the extended flag. In word mode a signed remainder is sign-extended to 64 bits and an unsigned one is zero-extended.
- R9: With the record flag, `cond_wen` is high with the result, `cond_mask` is 0x80, and `cond_data` bits 31:28 are {LT, GT, EQ, 0}, with bits 27:0 zero. The compare is signed, of the 64-bit result against zero; a positive result gives 0x40000000. Without the flag, `cond_wen` stays low.
- R10: A `start` seen while busy is ignored. Busy runs from the accepting edge up to and including the edge that raises `res_valid`. A `start` present during the cycle `res_valid` is high is accepted.
- R11: Synchronous active-low reset returns the unit to idle with `res_valid`, `res_wen` and `cond_wen` low, and abandons any division in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, taken when idle |
| dividend | input | 64 | Dividend operand |
| divisor | input | 64 | Divisor operand |
| dest_reg | input | 5 | Destination register number |
| op_signed | input | 1 | Two's-complement operands |
| op_word | input | 1 | 32-bit operation on low words |
| op_extended | input | 1 | Dividend shifted left by operand width |
| op_modulus | input | 1 | Return remainder instead of quotient |
| op_record | input | 1 | Also write the condition field |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 64 | Write-back value |
| res_dest | output | 5 | Destination register number returned |
| res_wen | output | 1 | Register write enable |
| cond_wen | output | 1 | Condition field write enable |
| cond_mask | output | 8 | Condition field select mask |
| cond_data | output | 32 | Condition value, field in bits 31:28 |

## Verification
Result delivery and acceptance of the next request can fall in the same cycle. The bench provokes this by driving `start` during the cycle in which `res_valid` is seen high. It then judges the second result by its value, its destination number and its exact 65-edge latency. The neighbouring cycle is provoked as well: a request placed one cycle before `res_valid` rises must be dropped. That is judged by the first result arriving intact and no second strobe appearing for 80 cycles.

// File: rtl/divu_pkg.sv
// Shared types for the iterative divider.
// Assumes: operand width is even so that a word is half of it.
package divu_pkg;

    // Operation mode as captured with a request
    typedef struct packed {
        logic sgn;
        logic word;
        logic ext;
        logic modu;
        logic rec;
    } div_mode_t;

    // Facts derived from the operands before iteration starts
    typedef struct packed {
        logic neg_q;    // quotient must be negated
        logic neg_r;    // remainder must be negated
        logic b_zero;   // effective divisor is zero
        logic pre_ovf;  // extended 64-bit quotient cannot fit
    } div_flags_t;

    localparam logic [7:0] COND_SEL = 8'h80;

endpackage

// File: rtl/div_operand_prep.sv
// Operand preparation: selects word or full operands, takes magnitudes
// and builds the high/low halves of the numerator for the loop.
// Assumes: combinational, sampled by the caller on the accepting edge.
module div_operand_prep
    import divu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         sgn,
    input  logic         word,
    input  logic         ext,
    input  logic         modu,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] num_hi,
    output logic [W-1:0] num_lo,
    output logic [W-1:0] den,
    output div_flags_t   flags
);
    localparam int H = W / 2;

    logic [W-1:0] a_ext, b_ext, a_mag, b_mag;
    logic         a_neg, b_neg;

    // Width selection and magnitudes
    always_comb begin
        if (word) begin
            a_ext = sgn ? {{H{a[H-1]}}, a[H-1:0]} : {{H{1'b0}}, a[H-1:0]};
            b_ext = sgn ? {{H{b[H-1]}}, b[H-1:0]} : {{H{1'b0}}, b[H-1:0]};
        end else begin
            a_ext = a;
            b_ext = b;
        end
        a_neg = sgn && a_ext[W-1];
        b_neg = sgn && b_ext[W-1];
        a_mag = a_neg ? -a_ext : a_ext;
        b_mag = b_neg ? -b_ext : b_ext;
    end

    // Numerator layout and overflow pre-check
    always_comb begin
        num_hi        = '0;
        num_lo        = a_mag;
        den           = b_mag;
        flags.neg_q   = a_neg ^ b_neg;
        flags.neg_r   = a_neg;
        flags.b_zero  = (b_ext == '0);
        flags.pre_ovf = 1'b0;
        if (ext && !modu) begin
            if (word) begin
                num_lo = {a_mag[H-1:0], {H{1'b0}}};
            end else begin
                num_hi        = a_mag;
                num_lo        = '0;
                flags.pre_ovf = (a_mag >= b_mag);
            end
        end
    end
endmodule

// File: rtl/div_iter_core.sv
// Restoring shift-subtract loop, one quotient bit per cycle, W cycles.
// Assumes: num_hi < den on load when the result is to be used; load
// is only raised while idle.
module div_iter_core #(
    parameter int W  = 64,
    parameter int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] num_hi,
    input  logic [W-1:0] num_lo,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  r_q, q_q, d_q;
    logic [CW-1:0] cnt;
    logic [W:0]    trial, diff;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        trial = {r_q, q_q[W-1]};
        diff  = trial - {1'b0, d_q};
    end

    // Iteration state, step counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q  <= '0;
            q_q  <= '0;
            d_q  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                r_q  <= num_hi;
                q_q  <= num_lo;
                d_q  <= den;
                cnt  <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                if (!diff[W]) begin
                    r_q <= diff[W-1:0];
                    q_q <= {q_q[W-2:0], 1'b1};
                end else begin
                    r_q <= trial[W-1:0];
                    q_q <= {q_q[W-2:0], 1'b0};
                end
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = q_q;
    assign rem = r_q;

    // Completion only ever follows an active iteration (R2)
    p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    // The top never reloads a running loop (R10)
    p_no_load_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);
endmodule

// File: rtl/div_result_fmt.sv
// Result formatting: sign correction, range check, word packing and
// the 4-bit condition code from a signed compare against zero.
// Assumes: quo/rem are magnitudes from a completed loop.
module div_result_fmt
    import divu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         sgn,
    input  logic         word,
    input  logic         modu,
    input  div_flags_t   flags,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] rem,
    output logic [W-1:0] value,
    output logic [3:0]   cond4
);
    localparam int H = W / 2;
    localparam logic [H-1:0] MIN_H = {1'b1, {(H-1){1'b0}}};
    localparam logic [W-1:0] MIN_W = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] qs, rs;
    logic         fits;

    // Signed values and destination-range check on the quotient magnitude
    always_comb begin
        qs = flags.neg_q ? -quo : quo;
        rs = flags.neg_r ? -rem : rem;
        if (!sgn)
            fits = word ? (quo[W-1:H] == '0) : 1'b1;
        else if (word)
            fits = (quo[W-1:H] == '0) &&
                   (!quo[H-1] || (flags.neg_q && quo[H-1:0] == MIN_H));
        else
            fits = !quo[W-1] || (flags.neg_q && quo == MIN_W);
    end

    // Final write-back value selection
    always_comb begin
        if (flags.b_zero)
            value = '0;
        else if (modu)
            value = !word ? rs :
                    sgn   ? {{H{rs[H-1]}}, rs[H-1:0]} : {{H{1'b0}}, rs[H-1:0]};
        else if (flags.pre_ovf || !fits)
            value = '0;
        else
            value = word ? {{H{1'b0}}, qs[H-1:0]} : qs;
    end

    // Condition nibble {LT, GT, EQ, 0}
    always_comb begin
        cond4[3] = value[W-1];
        cond4[1] = (value == '0);
        cond4[2] = !cond4[3] && !cond4[1];
        cond4[0] = 1'b0;
    end

    // Exactly one of LT/GT/EQ is set (R9)
    always_comb begin
        a_cond_onehot_r9: assert ($countones(cond4[3:1]) == 1);
    end
endmodule

// File: rtl/int_divider.sv
// Top of the iterative divider: request capture, loop control and the
// registered one-cycle result strobe.
// Assumes: start is taken only when neither iterating nor finishing.
module int_divider
    import divu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    input  logic [REG_W-1:0]  dest_reg,
    input  logic              op_signed,
    input  logic              op_word,
    input  logic              op_extended,
    input  logic              op_modulus,
    input  logic              op_record,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [REG_W-1:0]  res_dest,
    output logic              res_wen,
    output logic              cond_wen,
    output logic [7:0]        cond_mask,
    output logic [31:0]       cond_data
);
    localparam int CW  = $clog2(DATA_W);
    localparam int LCW = $clog2(DATA_W + 4) + 1;

    div_mode_t         mode_in, mode_q;
    div_flags_t        flags_in, flags_q;
    logic [REG_W-1:0]  dest_q;
    logic [DATA_W-1:0] num_hi, num_lo, den, quo, rem, value;
    logic [3:0]        cond4;
    logic              busy, done, accept;

    assign mode_in = '{sgn: op_signed, word: op_word, ext: op_extended,
                       modu: op_modulus, rec: op_record};
    assign accept  = start && !busy && !done;

    div_operand_prep #(.W(DATA_W)) u_prep (
        .sgn(mode_in.sgn), .word(mode_in.word), .ext(mode_in.ext),
        .modu(mode_in.modu), .a(dividend), .b(divisor),
        .num_hi(num_hi), .num_lo(num_lo), .den(den), .flags(flags_in)
    );

    div_iter_core #(.W(DATA_W), .CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .num_hi(num_hi), .num_lo(num_lo), .den(den),
        .busy(busy), .done(done), .quo(quo), .rem(rem)
    );

    div_result_fmt #(.W(DATA_W)) u_fmt (
        .sgn(mode_q.sgn), .word(mode_q.word), .modu(mode_q.modu),
        .flags(flags_q), .quo(quo), .rem(rem), .value(value), .cond4(cond4)
    );

    // Request capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            flags_q <= '0;
            dest_q  <= '0;
        end else if (accept) begin
            mode_q  <= mode_in;
            flags_q <= flags_in;
            dest_q  <= dest_reg;
        end
    end

    // Registered result strobe and write-back fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_wen   <= 1'b0;
            cond_wen  <= 1'b0;
            res_data  <= '0;
            res_dest  <= '0;
            cond_mask <= '0;
            cond_data <= '0;
        end else begin
            res_valid <= done;
            res_wen   <= done;
            cond_wen  <= done && mode_q.rec;
            if (done) begin
                res_data  <= value;
                res_dest  <= dest_q;
                cond_mask <= mode_q.rec ? COND_SEL : 8'h00;
                cond_data <= mode_q.rec ? {cond4, 28'h0} : 32'h0;
            end
        end
    end

    // Checker: cycles elapsed since the last acceptance
    logic [LCW-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                lat_cnt <= '0;
        else if (accept)           lat_cnt <= '0;
        else if (!(&lat_cnt))      lat_cnt <= lat_cnt + 1'b1;
    end

    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (lat_cnt == LCW'(DATA_W + 1)));
    p_zero_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && flags_q.b_zero) |-> (res_data == '0));
    p_ext_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && flags_q.pre_ovf && mode_q.ext && !mode_q.modu) |-> (res_data == '0));
    p_cond_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cond_wen |-> (res_valid && cond_mask == COND_SEL));
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(dest_q));
    p_reset_idle_r11: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !res_wen && !cond_wen));
endmodule

// File: tb/tb_int_divider.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, busy-time requests and back-to-back requests.
module tb_int_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] dividend = '0, divisor = '0;
    logic [4:0]  dest_reg = '0;
    logic        op_signed = 0, op_word = 0, op_extended = 0, op_modulus = 0, op_record = 0;
    logic        res_valid, res_wen, cond_wen;
    logic [63:0] res_data;
    logic [4:0]  res_dest;
    logic [7:0]  cond_mask;
    logic [31:0] cond_data;

    int n_chk = 0;
    int n_bad = 0;

    always #10ns clk = ~clk;  // 50 MHz

    int_divider dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
        .dest_reg(dest_reg), .op_signed(op_signed), .op_word(op_word),
        .op_extended(op_extended), .op_modulus(op_modulus), .op_record(op_record),
        .res_valid(res_valid), .res_data(res_data), .res_dest(res_dest), .res_wen(res_wen),
        .cond_wen(cond_wen), .cond_mask(cond_mask), .cond_data(cond_data)
    );

    // Flag order in the table: {signed, word, extended, modulus, record}
    localparam int NV = 24;
    localparam logic [63:0] VA [NV] = '{
        64'h10001000, 64'h10001000, 64'hFFFFFFFFFFFFFFF9, 64'hFFFFFFFFFFFFFF9C,
        64'hFFFFFFFFFFFFFFFF, 64'h5, 64'hFFFFFFFFFFFFFFF9, 64'h8000000000000000,
        64'hFFFFFFFF80000000, 64'h1, 64'h4, 64'h1,
        64'h1, 64'hFFFFFFFFFFFFFFFF, 64'hAAAAAAAAFFFFFFF8, 64'h1,
        64'h5, 64'h00000000FFFFFFFF, 64'hFFFFFFFFFFFFFFF9, 64'h7,
        64'h12345678FFFFFFF9, 64'hFFFFFFFF00000007, 64'h64, 64'hFFFFFFFF0000000A};
    localparam logic [63:0] VB [NV] = '{
        64'h1111, 64'h1111, 64'h2, 64'hFFFFFFFFFFFFFFF9,
        64'h10, 64'h0, 64'h0, 64'hFFFFFFFFFFFFFFFF,
        64'hFFFFFFFFFFFFFFFF, 64'h4, 64'h4, 64'h4,
        64'h2, 64'h2, 64'h5555555500000002, 64'h4,
        64'h5, 64'h2, 64'h2, 64'hFFFFFFFFFFFFFFFE,
        64'h2, 64'h0000000500000003, 64'h7, 64'h3};
    localparam logic [4:0] VF [NV] = '{
        5'b00001, 5'b10001, 5'b10001, 5'b10000,
        5'b00000, 5'b00001, 5'b10011, 5'b10001,
        5'b11000, 5'b00100, 5'b00100, 5'b10100,
        5'b10100, 5'b10101, 5'b11001, 5'b01100,
        5'b01100, 5'b11100, 5'b10010, 5'b10011,
        5'b11010, 5'b01010, 5'b00110, 5'b01000};
    localparam logic [63:0] VE [NV] = '{
        64'hF001, 64'hF001, 64'hFFFFFFFFFFFFFFFD, 64'hE,
        64'h0FFFFFFFFFFFFFFF, 64'h0, 64'h0, 64'h0,
        64'h0, 64'h4000000000000000, 64'h0, 64'h4000000000000000,
        64'h0, 64'h8000000000000000, 64'h00000000FFFFFFFC, 64'h40000000,
        64'h0, 64'h0000000080000000, 64'hFFFFFFFFFFFFFFFF, 64'h1,
        64'hFFFFFFFFFFFFFFFF, 64'h1, 64'h2, 64'h3};
    localparam logic [3:0] VC [NV] = '{
        4'h4, 4'h4, 4'h8, 4'h0, 4'h0, 4'h2, 4'h2, 4'h2,
        4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h8, 4'h4, 4'h0,
        4'h0, 4'h0, 4'h0, 4'h4, 4'h0, 4'h0, 4'h0, 4'h0};
    // Requirement each vector targets: R1 R9 (0-4), R4 (5-6), R5 (7-8),
    // R6 (9-13), R7 (14-17, 23), R8 (18-22)
    localparam string VR [NV] = '{
        "R1/R9", "R1/R9", "R1/R9", "R1", "R1", "R4/R9", "R4", "R5/R9",
        "R5", "R6", "R6", "R6", "R6", "R6/R9", "R7/R9", "R7",
        "R7", "R7", "R8", "R8/R9", "R8", "R8", "R8", "R7"};

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; leaves the bench one falling edge later
    task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [4:0] f, input logic [4:0] d);
        dividend = a; divisor = b; dest_reg = d;
        {op_signed, op_word, op_extended, op_modulus, op_record} = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_valid(output int lat);
        lat = 1;
        while (!res_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic count_valids(input int cycles, output int n);
        n = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (res_valid) n++;
        end
    endtask

    initial begin
        int lat, nv;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(res_valid == 0, "R11 valid in reset", 64'(res_valid), 0);
        chk(res_wen == 0 && cond_wen == 0, "R11 enables in reset", 64'({res_wen, cond_wen}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [4:0] d;
            d = 5'(i) ^ 5'h11;
            issue(VA[i], VB[i], VF[i], d);
            wait_valid(lat);
            chk(lat == 66, {"R2 latency ", VR[i]}, 64'(lat), 66);
            chk(res_data == VE[i], {"result ", VR[i]}, res_data, VE[i]);
            chk(res_dest == d && res_wen, "R3 dest/wen", 64'({res_wen, res_dest}), 64'({1'b1, d}));
            if (VF[i][0]) begin
                chk(cond_wen && cond_mask == 8'h80, "R9 cond enable/mask", 64'({cond_wen, cond_mask}), 64'h180);
                chk(cond_data == {VC[i], 28'h0}, {"R9 cond data ", VR[i]}, 64'(cond_data), 64'({VC[i], 28'h0}));
            end else begin
                chk(!cond_wen, "R9 no record", 64'(cond_wen), 0);
            end
            @(negedge clk);
            chk(!res_valid, "R2 single-cycle strobe", 64'(res_valid), 0);
        end

        // R10: requests while busy and one cycle before the strobe are dropped
        issue(64'h10001000, 64'h1111, 5'b00000, 5'd3);
        repeat (9) @(negedge clk);
        issue(64'h64, 64'h7, 5'b00010, 5'd9);
        repeat (54) @(negedge clk);
        issue(64'h64, 64'h7, 5'b00010, 5'd9);
        chk(res_valid == 1, "R10 first result on time", 64'(res_valid), 1);
        chk(res_data == 64'hF001 && res_dest == 5'd3, "R10 first result intact", res_data, 64'hF001);
        count_valids(80, nv);
        chk(nv == 0, "R10 dropped requests produce nothing", 64'(nv), 0);

        // R10: request during the strobe cycle is accepted
        issue(64'h10001000, 64'h1111, 5'b10000, 5'd4);
        wait_valid(lat);
        chk(res_data == 64'hF001, "R10 first of pair", res_data, 64'hF001);
        issue(64'h64, 64'h7, 5'b00010, 5'd12);
        wait_valid(lat);
        chk(lat == 66, "R10 second latency", 64'(lat), 66);
        chk(res_data == 64'h2 && res_dest == 5'd12, "R10 second result", res_data, 64'h2);
        @(negedge clk);

        // R11: reset abandons a division in progress
        issue(64'h10001000, 64'h1111, 5'b00000, 5'd7);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(!res_valid, "R11 valid after reset", 64'(res_valid), 0);
        count_valids(80, nv);
        chk(nv == 0, "R11 abandoned division silent", 64'(nv), 0);
        issue(64'hFFFFFFFFFFFFFFF9, 64'h2, 5'b10000, 5'd8);
        wait_valid(lat);
        chk(res_data == 64'hFFFFFFFFFFFFFFFD && lat == 66, "R11 works after reset", res_data, 64'hFFFFFFFFFFFFFFFD);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule